// File: doc/BRIEF.md
# Management-Bus Register Access Responder with Indirection Window

This block sits on the switch side of a management bus and decodes register accesses that arrive as parallel requests. Each request carries a 5-bit bus address, a 5-bit register number, a write flag and 16 bits of write data. The block answers with a one-cycle `bus_done` pulse and, for reads, the returned data. A strap input sets the chip's own bus address. The strap is held stable while the block is out of reset.

When the strap is zero, the chip owns the whole bus. Every bus address is taken as an internal device address and forwarded to the on-chip register bank. When the strap is nonzero, the chip answers only its own address. There it offers two registers: a command register and a data register. A valid start command launches one internal access. A busy flag stays set until the bank finishes that access. Hosts poll the flag before and after each command.

The register bank sits outside the block. It is reached through a single-outstanding request/acknowledge handshake.

Top module: `smi_indirect_responder`

## Requirements
- R1: After synchronous reset, `bank_req` and `bus_done` are low, the busy flag is clear, and the command register reads back 0x0000.
- R2: With a zero strap, any request is forwarded to the bank, with the bus address as `bank_dev` and the register number as `bank_reg`. For reads, `bus_rdata` carries the bank's `bank_rdata`.
- R3: With a nonzero strap, a request to any other bus address causes no bank access and changes no state. A read there returns 0xFFFF.
- R4: At the own address, register 0 is the command register and register 1 is the data register. The data register can be written and read back. Any other register number reads 0xFFFF and ignores writes.
- R5: Command field positions are fixed: bit 15 is start/busy, bit 12 selects clause-22 style, bits 11:10 are the opcode, bits 9:5 are the device and bits 4:0 are the register. Opcode 01 writes the data register's content to the bank. Opcode 10 reads from the bank.
- R6: An accepted command sets busy from the cycle after it is written until the cycle after the bank acknowledges. A command register read returns the live busy flag in bit 15 and the stored command in bits 14:0.
- R7: When an indirect read completes, the bank's data is in the data register by the time busy reads clear.
- R8: A command written with bit 15 clear launches nothing and leaves the stored command unchanged.
- R9: A command written while busy is set is dropped. This includes a write that lands on the same clock edge as the bank acknowledge. The access in flight finishes unchanged.
- R10: A command with bit 15 set is stored but does not launch if either of these holds: bit 12 is clear, or the opcode is not 01 or 10. Busy stays clear.
- R11: Once `bank_req` is raised, it stays high with stable device, register, write flag and write data until `bank_ack` is seen. Only one bank access is outstanding at a time.
- R12: Own-address and foreign-address requests complete with `bus_done` one cycle after the request. Forwarded requests complete one cycle after the bank handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_addr | input | 5 | Own bus address; zero selects flat direct mode |
| req_valid | input | 1 | Request strobe; one cycle; the next may follow `bus_done` |
| req_addr | input | 5 | Bus address of the request |
| req_reg | input | 5 | Register number of the request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 16 | Write data |
| bus_done | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 16 | Read data, valid with `bus_done` |
| bank_req | output | 1 | Bank access request, held until acknowledged |
| bank_dev | output | 5 | Bank device address |
| bank_reg | output | 5 | Bank register number |
| bank_write | output | 1 | Bank access is a write |
| bank_wdata | output | 16 | Bank write data |
| bank_ack | input | 1 | Bank acknowledge, one cycle |
| bank_rdata | input | 16 | Bank read data, valid with `bank_ack` |

## Verification
Two things can meet in one cycle: the bank acknowledge that ends an indirect access, and a host write of a new command. The bench sets the bank model's latency to zero and issues a read command. It then puts the next command write on the bus in the same half-cycle in which the model raises its acknowledge, so both reach the same clock edge. The outcome is judged at the ports. Only one bank handshake may be counted, the stored command must still be the first one with busy clear, and the data register must hold the value read by the first command.

// File: rtl/smi_resp_pkg.sv
package smi_resp_pkg;

    localparam int ADDR_W = 5;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;

    localparam logic [REG_W-1:0]  WIN_REG_CMD  = 5'd0;
    localparam logic [REG_W-1:0]  WIN_REG_DATA = 5'd1;
    localparam logic [DATA_W-1:0] FLOAT_WORD   = '1;

    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;

    // Command word: start/busy, two spare bits, clause-22 select, opcode, device, register
    typedef struct packed {
        logic              start;
        logic [1:0]        spare;
        logic              c22;
        logic [1:0]        opc;
        logic [ADDR_W-1:0] dev;
        logic [REG_W-1:0]  regn;
    } win_cmd_t;

    typedef enum logic [1:0] {
        ACC_FOREIGN = 2'd0,
        ACC_DIRECT  = 2'd1,
        ACC_LOCAL   = 2'd2
    } acc_kind_e;

    function automatic logic cmd_launches(win_cmd_t c);
        return c.start && c.c22 && (c.opc == OPC_WRITE || c.opc == OPC_READ);
    endfunction

endpackage

// File: rtl/smi_addr_match.sv
module smi_addr_match
    import smi_resp_pkg::*;
(
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic [ADDR_W-1:0] bus_addr,
    output acc_kind_e         kind
);
    always_comb begin
        if (strap_addr == '0)
            kind = ACC_DIRECT;
        else if (bus_addr == strap_addr)
            kind = ACC_LOCAL;
        else
            kind = ACC_FOREIGN;
    end
endmodule

// File: rtl/smi_bank_port.sv
module smi_bank_port
    import smi_resp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] s_dev,
    input  logic [REG_W-1:0]  s_reg,
    input  logic              s_write,
    input  logic [DATA_W-1:0] s_wdata,
    output logic              bank_req,
    output logic [ADDR_W-1:0] bank_dev,
    output logic [REG_W-1:0]  bank_reg,
    output logic              bank_write,
    output logic [DATA_W-1:0] bank_wdata,
    input  logic              bank_ack,
    input  logic [DATA_W-1:0] bank_rdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bank_req   <= 1'b0;
            bank_dev   <= '0;
            bank_reg   <= '0;
            bank_write <= 1'b0;
            bank_wdata <= '0;
        end else if (bank_req) begin
            if (bank_ack)
                bank_req <= 1'b0;
        end else if (start) begin
            bank_req   <= 1'b1;
            bank_dev   <= s_dev;
            bank_reg   <= s_reg;
            bank_write <= s_write;
            bank_wdata <= s_wdata;
        end
    end

    assign done  = bank_req && bank_ack;
    assign rdata = bank_rdata;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        bank_req && !bank_ack |=> bank_req && $stable(bank_dev) && $stable(bank_reg)
                                 && $stable(bank_write) && $stable(bank_wdata)); // R11
endmodule

// File: rtl/smi_cmd_window.sv
module smi_cmd_window
    import smi_resp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bank_done,
    input  logic [DATA_W-1:0] bank_rdata,
    output logic [DATA_W-1:0] rd_value,
    output logic              busy,
    output logic              launch,
    output logic [ADDR_W-1:0] l_dev,
    output logic [REG_W-1:0]  l_reg,
    output logic              l_write,
    output logic [DATA_W-1:0] l_wdata
);
    win_cmd_t          cmd_q;
    logic [DATA_W-1:0] data_q;
    win_cmd_t          cmd_in;
    logic              cmd_wr;

    assign cmd_in  = win_cmd_t'(wdata);
    assign cmd_wr  = wr_en && (reg_sel == WIN_REG_CMD);
    assign launch  = cmd_wr && !busy && cmd_launches(cmd_in);
    assign l_dev   = cmd_in.dev;
    assign l_reg   = cmd_in.regn;
    assign l_write = (cmd_in.opc == OPC_WRITE);
    assign l_wdata = data_q;

    always_comb begin
        case (reg_sel)
            WIN_REG_CMD:  rd_value = {busy, cmd_q[DATA_W-2:0]};
            WIN_REG_DATA: rd_value = data_q;
            default:      rd_value = FLOAT_WORD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            data_q <= '0;
            busy   <= 1'b0;
        end else begin
            if (cmd_wr && !busy && cmd_in.start) begin
                cmd_q <= cmd_in;
                busy  <= cmd_launches(cmd_in);
            end
            if (wr_en && reg_sel == WIN_REG_DATA)
                data_q <= wdata;
            if (busy && bank_done) begin
                busy <= 1'b0;
                if (cmd_q.opc == OPC_READ)
                    data_q <= bank_rdata;
            end
        end
    end

    AST_DROP_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy && cmd_wr |=> $stable(cmd_q)); // R9
    AST_UNSTARTED_KEEPS: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && !cmd_in.start |=> $stable(cmd_q)); // R8
endmodule

// File: rtl/smi_indirect_responder.sv
module smi_indirect_responder
    import smi_resp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        strap_addr,
    input  logic              req_valid,
    input  logic [4:0]        req_addr,
    input  logic [4:0]        req_reg,
    input  logic              req_write,
    input  logic [15:0]       req_wdata,
    output logic              bus_done,
    output logic [15:0]       bus_rdata,
    output logic              bank_req,
    output logic [4:0]        bank_dev,
    output logic [4:0]        bank_reg,
    output logic              bank_write,
    output logic [15:0]       bank_wdata,
    input  logic              bank_ack,
    input  logic [15:0]       bank_rdata
);
    acc_kind_e         kind;
    logic              pend_q;
    logic              req_go;
    logic              direct_go;
    logic              local_go;
    logic [DATA_W-1:0] win_rd;
    logic              win_busy;
    logic              win_launch;
    logic [ADDR_W-1:0] win_dev;
    logic [REG_W-1:0]  win_reg;
    logic              win_write;
    logic [DATA_W-1:0] win_wdata;
    logic              port_start;
    logic              port_done;
    logic [DATA_W-1:0] port_rdata;
    logic              bus_done_q;
    logic [DATA_W-1:0] bus_rdata_q;

    smi_addr_match u_match (
        .strap_addr (strap_addr),
        .bus_addr   (req_addr),
        .kind       (kind)
    );

    assign req_go    = req_valid && !pend_q;
    assign direct_go = req_go && (kind == ACC_DIRECT);
    assign local_go  = req_go && (kind == ACC_LOCAL);

    smi_cmd_window u_window (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (local_go && req_write),
        .reg_sel    (req_reg),
        .wdata      (req_wdata),
        .bank_done  (port_done),
        .bank_rdata (port_rdata),
        .rd_value   (win_rd),
        .busy       (win_busy),
        .launch     (win_launch),
        .l_dev      (win_dev),
        .l_reg      (win_reg),
        .l_write    (win_write),
        .l_wdata    (win_wdata)
    );

    assign port_start = direct_go || win_launch;

    smi_bank_port u_port (
        .clk        (clk),
        .rst        (rst),
        .start      (port_start),
        .s_dev      (direct_go ? req_addr  : win_dev),
        .s_reg      (direct_go ? req_reg   : win_reg),
        .s_write    (direct_go ? req_write : win_write),
        .s_wdata    (direct_go ? req_wdata : win_wdata),
        .bank_req   (bank_req),
        .bank_dev   (bank_dev),
        .bank_reg   (bank_reg),
        .bank_write (bank_write),
        .bank_wdata (bank_wdata),
        .bank_ack   (bank_ack),
        .bank_rdata (bank_rdata),
        .done       (port_done),
        .rdata      (port_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            bus_done_q  <= 1'b0;
            bus_rdata_q <= FLOAT_WORD;
        end else begin
            bus_done_q <= (req_go && kind != ACC_DIRECT) || (pend_q && port_done);
            if (pend_q && port_done) begin
                pend_q      <= 1'b0;
                bus_rdata_q <= port_rdata;
            end else if (direct_go) begin
                pend_q <= 1'b1;
            end else if (req_go) begin
                bus_rdata_q <= (kind == ACC_LOCAL) ? win_rd : FLOAT_WORD;
            end
        end
    end

    assign bus_done  = bus_done_q;
    assign bus_rdata = bus_rdata_q;

    AST_BUSY_TRACKS_REQ: assert property (@(posedge clk) disable iff (rst)
        (strap_addr != '0) |-> (win_busy == bank_req)); // R6
    AST_FOREIGN_FLOATS: assert property (@(posedge clk) disable iff (rst)
        req_go && kind == ACC_FOREIGN && !req_write |=> bus_done && bus_rdata == FLOAT_WORD); // R3
    AST_FOREIGN_NO_BANK: assert property (@(posedge clk) disable iff (rst)
        req_go && kind == ACC_FOREIGN && !bank_req |=> !bank_req); // R3
    AST_DIRECT_DONE: assert property (@(posedge clk) disable iff (rst)
        pend_q && bank_req && bank_ack |=> bus_done); // R12
endmodule

// File: tb/test_smi_indirect_responder.sv
module test_smi_indirect_responder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  strap_addr = 5'd0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [4:0]  req_reg = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        bus_done;
    logic [15:0] bus_rdata;
    logic        bank_req;
    logic [4:0]  bank_dev;
    logic [4:0]  bank_reg;
    logic        bank_write;
    logic [15:0] bank_wdata;
    logic        bank_ack = 1'b0;
    logic [15:0] bank_rdata = '0;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    smi_indirect_responder i_smi_indirect_responder (
        .clk(clk), .rst(rst), .strap_addr(strap_addr),
        .req_valid(req_valid), .req_addr(req_addr), .req_reg(req_reg),
        .req_write(req_write), .req_wdata(req_wdata),
        .bus_done(bus_done), .bus_rdata(bus_rdata),
        .bank_req(bank_req), .bank_dev(bank_dev), .bank_reg(bank_reg),
        .bank_write(bank_write), .bank_wdata(bank_wdata),
        .bank_ack(bank_ack), .bank_rdata(bank_rdata)
    );

    function automatic logic [15:0] pat(input logic [4:0] d, input logic [4:0] r);
        return {1'b1, d, r, 5'b01101};
    endfunction

    // bank model
    logic [15:0] mem    [0:31][0:31];
    logic [15:0] shadow [0:31][0:31];
    int          lat = 0;
    int          wait_cnt = 0;
    int          hs_cnt = 0;
    logic [4:0]  last_dev = '0;
    logic [4:0]  last_reg = '0;

    always @(negedge clk) begin
        if (bank_req && !bank_ack) begin
            if (wait_cnt >= lat) begin
                bank_ack   = 1'b1;
                bank_rdata = mem[bank_dev][bank_reg];
                if (bank_write) mem[bank_dev][bank_reg] = bank_wdata;
                last_dev = bank_dev;
                last_reg = bank_reg;
                hs_cnt++;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end else begin
            bank_ack = 1'b0;
        end
    end

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
            summary_and_end();
        end
    end

    task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge where bus_done is seen
    task automatic xfer(input logic [4:0] a, input logic [4:0] r, input logic w,
                        input logic [15:0] d, output logic [15:0] rd, output int latency);
        req_valid = 1'b1; req_addr = a; req_reg = r; req_write = w; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        latency = 1;
        while (!bus_done && latency < 200) begin
            @(negedge clk);
            latency++;
        end
        rd = bus_rdata;
    endtask

    task automatic do_reset(input logic [4:0] s);
        strap_addr = s;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    localparam logic [4:0] OWN = 5'd5;

    // wr, addr, reg, data
    localparam logic [26:0] VEC [0:7] = '{
        {1'b0, 5'd3,  5'd4,  16'h0000},
        {1'b1, 5'd3,  5'd4,  16'hBEEF},
        {1'b0, 5'd3,  5'd4,  16'h0000},
        {1'b0, 5'd31, 5'd31, 16'h0000},
        {1'b1, 5'd0,  5'd0,  16'h1234},
        {1'b0, 5'd0,  5'd0,  16'h0000},
        {1'b1, 5'd17, 5'd9,  16'h5A5A},
        {1'b0, 5'd17, 5'd9,  16'h0000}
    };

    task automatic poll_idle();
        logic [15:0] rd;
        int lt;
        int guard;
        guard = 0;
        rd = 16'h8000;
        while (rd[15] && guard < 100) begin
            xfer(OWN, 5'd0, 1'b0, 16'h0, rd, lt);
            guard++;
        end
    endtask

    initial begin
        logic [15:0] rd;
        int lt;
        int h0;
        for (int d = 0; d < 32; d++)
            for (int r = 0; r < 32; r++) begin
                mem[d][r]    = pat(5'(d), 5'(r));
                shadow[d][r] = pat(5'(d), 5'(r));
            end

        // R1 reset state, direct mode
        do_reset(5'd0);
        check(!bank_req && !bus_done, "R1 idle after reset", {14'b0, bank_req, bus_done}, 16'h0);

        // R2 direct forwarding, table walk
        lat = 2;
        for (int i = 0; i < 8; i++) begin
            logic [26:0] v;
            v = VEC[i];
            xfer(v[25:21], v[20:16], v[26], v[15:0], rd, lt);
            check(last_dev == v[25:21] && last_reg == v[20:16], "R2 forwarded address",
                  {6'b0, last_dev, last_reg}, {6'b0, v[25:21], v[20:16]});
            if (v[26]) shadow[v[25:21]][v[20:16]] = v[15:0];
            else check(rd == shadow[v[25:21]][v[20:16]], "R2 direct read data", rd,
                       shadow[v[25:21]][v[20:16]]);
        end
        lat = 4;
        xfer(5'd12, 5'd1, 1'b0, 16'h0, rd, lt);
        check(lt == lat + 2, "R12 direct completion latency", 16'(lt), 16'(lat + 2));

        // indirect mode
        do_reset(OWN);
        xfer(OWN, 5'd0, 1'b0, 16'h0, rd, lt);
        check(rd == 16'h0000, "R1 command reset value", rd, 16'h0000);
        check(lt == 1, "R12 local latency", 16'(lt), 16'd1);

        h0 = hs_cnt;
        xfer(5'd6, 5'd1, 1'b0, 16'h0, rd, lt);
        check(rd == 16'hFFFF && lt == 1, "R3 foreign read floats", rd, 16'hFFFF);
        xfer(5'd0, 5'd1, 1'b1, 16'h1111, rd, lt);
        xfer(OWN, 5'd1, 1'b0, 16'h0, rd, lt);
        check(rd == 16'h0000 && hs_cnt == h0, "R3 foreign write ignored", rd, 16'h0000);

        xfer(OWN, 5'd7, 1'b1, 16'h2222, rd, lt);
        xfer(OWN, 5'd7, 1'b0, 16'h0, rd, lt);
        check(rd == 16'hFFFF, "R4 unused register reads float", rd, 16'hFFFF);
        xfer(OWN, 5'd1, 1'b1, 16'hCAFE, rd, lt);
        xfer(OWN, 5'd1, 1'b0, 16'h0, rd, lt);
        check(rd == 16'hCAFE, "R4 data register readback", rd, 16'hCAFE);

        // R5/R6 indirect write: dev 4 reg 2
        lat = 3;
        xfer(OWN, 5'd1, 1'b1, 16'h4321, rd, lt);
        xfer(OWN, 5'd0, 1'b1, 16'h9482, rd, lt);
        xfer(OWN, 5'd0, 1'b0, 16'h0, rd, lt);
        check(rd == 16'h9482, "R6 busy visible while pending", rd, 16'h9482);
        poll_idle();
        xfer(OWN, 5'd0, 1'b0, 16'h0, rd, lt);
        check(rd == 16'h1482, "R6 busy clear after completion", rd, 16'h1482);
        check(mem[4][2] == 16'h4321, "R5 indirect write reached bank", mem[4][2], 16'h4321);

        // R7 indirect read: dev 9 reg 3
        xfer(OWN, 5'd0, 1'b1, 16'h9923, rd, lt);
        poll_idle();
        xfer(OWN, 5'd1, 1'b0, 16'h0, rd, lt);
        check(rd == pat(5'd9, 5'd3), "R7 read result in data register", rd, pat(5'd9, 5'd3));

        // R8 no start bit
        h0 = hs_cnt;
        xfer(OWN, 5'd0, 1'b1, 16'h1CA5, rd, lt);
        repeat (6) @(negedge clk);
        xfer(OWN, 5'd0, 1'b0, 16'h0, rd, lt);
        check(rd == 16'h1923 && hs_cnt == h0, "R8 unstarted command ignored", rd, 16'h1923);

        // R9 command while busy: read dev 2 reg 7, then write attempt
        lat = 6;
        h0 = hs_cnt;
        xfer(OWN, 5'd0, 1'b1, 16'h9847, rd, lt);
        xfer(OWN, 5'd0, 1'b1, 16'h9482, rd, lt);
        poll_idle();
        xfer(OWN, 5'd0, 1'b0, 16'h0, rd, lt);
        check(rd == 16'h1847, "R9 busy command dropped", rd, 16'h1847);
        xfer(OWN, 5'd1, 1'b0, 16'h0, rd, lt);
        check(rd == pat(5'd2, 5'd7) && hs_cnt == h0 + 1, "R9 access in flight intact", rd, pat(5'd2, 5'd7));

        // R9 same edge as acknowledge: read dev 5 reg 5, lat 0
        lat = 0;
        h0 = hs_cnt;
        xfer(OWN, 5'd0, 1'b1, 16'h98A5, rd, lt);
        xfer(OWN, 5'd0, 1'b1, 16'h9482, rd, lt);
        repeat (4) @(negedge clk);
        xfer(OWN, 5'd0, 1'b0, 16'h0, rd, lt);
        check(rd == 16'h18A5, "R9 command on ack edge dropped", rd, 16'h18A5);
        xfer(OWN, 5'd1, 1'b0, 16'h0, rd, lt);
        check(rd == pat(5'd5, 5'd5) && hs_cnt == h0 + 1, "R9 ack edge single handshake", rd, pat(5'd5, 5'd5));

        // R10 unsupported opcode / clause select
        h0 = hs_cnt;
        xfer(OWN, 5'd0, 1'b1, 16'h8C85, rd, lt);
        xfer(OWN, 5'd0, 1'b0, 16'h0, rd, lt);
        check(rd == 16'h0C85 && hs_cnt == h0 && !bank_req, "R10 unsupported command stored only", rd, 16'h0C85);

        // R11 stable request over a long wait
        lat = 5;
        xfer(OWN, 5'd1, 1'b1, 16'h7777, rd, lt);
        xfer(OWN, 5'd0, 1'b1, 16'h95AA, rd, lt);
        poll_idle();
        check(last_dev == 5'd13 && last_reg == 5'd10 && mem[13][10] == 16'h7777,
              "R11 request fields held to ack", mem[13][10], 16'h7777);

        summary_and_end();
    end
endmodule